// File: doc/BRIEF.md
# Burst Bus Initiator with Flow Control

This block is the initiating side of a synchronous burst bus whose address and data share one set of lines. A client loads a command, a start address and a word count and pulses a start input. The initiator asks the arbiter for the bus and, once it holds the grant and sees the bus idle, opens a tenure. It raises the frame signal and drives command and address for one cycle, then moves data words. A word moves only on a rising edge where both its own ready and the target's ready are high. The addresses step by one word each time.

The end of a burst is announced in advance: frame is lowered while the final word of the tenure is still pending. The target can cut a tenure short with a stop request, marked as a retry or an abort. A retry makes the initiator arbitrate again and continue from the first word not yet moved. An abort ends the transaction and discards the rest. If the arbiter withdraws the grant during the data phase, the next word becomes the last of the tenure and the remainder follows in a fresh tenure. Every tenure closes with one cycle in which the initiator drives nothing, so that ownership of shared lines can pass without contention.

The FSM states are IDLE, ARB (requesting), ADDR (address phase), TURN (read turnaround), DATA and RECOVER (release cycle). The transitions are: IDLE→ARB on start; ARB→ADDR on grant with bus idle; ADDR→DATA for a write; ADDR→TURN for a read; TURN→DATA; DATA→RECOVER on stop or on a transfer made with frame low; RECOVER→ARB if words remain and there was no abort; RECOVER→IDLE otherwise.

Top module: `burst_initiator`

## Requirements
- R1: After reset, busy_o, bus_req_o, frame_o, irdy_o, ctl_oe_o, ad_oe_o, done_o and rd_valid_o are all low.
- R2: After start_i, bus_req_o rises. The address phase begins only after an edge with both bus_gnt_i and bus_idle_i high. In that cycle frame_o, ctl_oe_o and ad_oe_o are high, ad_o carries the address of the next word and cbe_o carries the command. Command bit 0 selects the direction: 1 means write and 0 means read.
- R3: A word moves only on an edge where irdy_o and trdy_i are both high. Word addresses rise by 4 per word from the start address. During a write data cycle ad_oe_o is high and ad_o equals wr_data_i, which is the data for cur_addr_o.
- R4: During a data cycle, frame_o is low exactly when one word is left, when the grant is absent, or when frame was already lowered earlier in the same tenure. Once lowered, it stays low until the tenure ends.
- R5: irdy_o stays high from the first data cycle of a tenure until its final word moves or a stop is seen. A write has no cycle between the address phase and the first data cycle.
- R6: The word count comes from len_i, and a value of 0 is treated as 1. Without a stop or a lost grant, a transaction moves exactly that many words in one tenure.
- R7: A read puts one turnaround cycle between the address phase and the first data cycle. In that cycle ad_oe_o and irdy_o are low. Each word read appears on rd_data_o with rd_valid_o high one cycle after its edge, and rd_addr_o gives its address.
- R8: A stop with tgt_sel_i high is a retry. It ends the tenure after that edge, and the word counts as moved if trdy_i was also high. The initiator then re-arbitrates and continues from the first word not yet moved.
- R9: A stop with tgt_sel_i low is an abort. It ends the transaction: done_o pulses with abort_o high, and the remaining words are dropped.
- R10: A grant withdrawn during the data phase makes the next word the last one of the tenure. Any remaining words are moved in a new tenure.
- R11: Each tenure ends with one cycle in which ctl_oe_o and ad_oe_o are low. done_o pulses in that cycle when the transaction is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a transaction when idle |
| cmd_i | input | DW/8 | Bus command; bit 0 set means write |
| addr_i | input | DW | Byte address of the first word |
| len_i | input | LW | Number of words (0 is treated as 1) |
| wr_data_i | input | DW | Write data for the word at cur_addr_o |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when the transaction ends |
| abort_o | output | 1 | Last transaction ended by abort |
| cur_addr_o | output | DW | Address of the next word to move |
| rd_valid_o | output | 1 | Read word valid |
| rd_data_o | output | DW | Read word |
| rd_addr_o | output | DW | Address of the read word |
| bus_req_o | output | 1 | Request to the arbiter |
| bus_gnt_i | input | 1 | Grant from the arbiter |
| bus_idle_i | input | 1 | Shared bus has no active tenure |
| frame_o | output | 1 | Frame, high while more than the final word remains |
| irdy_o | output | 1 | Initiator ready |
| ctl_oe_o | output | 1 | Drive enable for frame, ready and command lines |
| cbe_o | output | DW/8 | Command in the address phase, byte enables after it |
| ad_o | output | DW | Multiplexed address/data out |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | DW | Multiplexed address/data in |
| trdy_i | input | 1 | Target ready |
| stop_i | input | 1 | Target stop request |
| tgt_sel_i | input | 1 | Target still selected; with stop means retry, else abort |

## Verification
Some properties are checked by the assertions on every cycle. These are the frame and ready hold rules during wait states, that the address phase appears with the command on the lines, the read turnaround after the address, the release cycle after each data phase, and that read captures only follow real transfers. The bench scenarios are needed for the rest. They sweep lengths, wait states and both directions and compare every transferred address and data word against arithmetic expectations. They also show how a transaction is split into tenures after a retry or a lost grant, that an abort drops the remaining words, and that arbitration holds off while the bus is busy.

// File: rtl/bbi_pkg.sv
package bbi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_ADDR,
        ST_TURN,
        ST_DATA,
        ST_RECOVER
    } bbi_state_t;
endpackage

// File: rtl/bbi_word_tracker.sv
module bbi_word_tracker #(
    parameter int DW   = 32,
    parameter int LW   = 6,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] load_addr_i,
    input  logic [LW-1:0] load_len_i,
    input  logic          advance_i,
    output logic [DW-1:0] addr_o,
    output logic [LW-1:0] rem_o,
    output logic          one_left_o
);
    localparam logic [DW-1:0] STEP_V = DW'(STEP);
    localparam logic [LW-1:0] ONE_V  = LW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            rem_o  <= '0;
        end else if (load_i) begin
            addr_o <= load_addr_i;
            rem_o  <= (load_len_i == '0) ? ONE_V : load_len_i;
        end else if (advance_i) begin
            addr_o <= addr_o + STEP_V;
            rem_o  <= rem_o - ONE_V;
        end
    end

    assign one_left_o = (rem_o == ONE_V);

    // R6: a word never moves with nothing left to move
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |-> (rem_o != '0));
endmodule

// File: rtl/bbi_read_capture.sv
module bbi_read_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] addr_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    output logic [DW-1:0] addr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            addr_o  <= '0;
        end else begin
            valid_o <= capture_i;
            if (capture_i) begin
                data_o <= data_i;
                addr_o <= addr_i;
            end
        end
    end
endmodule

// File: rtl/burst_initiator.sv
module burst_initiator
    import bbi_pkg::*;
#(
    parameter int DW = 32,
    parameter int LW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DW/8-1:0]   cmd_i,
    input  logic [DW-1:0]     addr_i,
    input  logic [LW-1:0]     len_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              abort_o,
    output logic [DW-1:0]     cur_addr_o,
    output logic              rd_valid_o,
    output logic [DW-1:0]     rd_data_o,
    output logic [DW-1:0]     rd_addr_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    input  logic              bus_idle_i,
    output logic              frame_o,
    output logic              irdy_o,
    output logic              ctl_oe_o,
    output logic [DW/8-1:0]   cbe_o,
    output logic [DW-1:0]     ad_o,
    output logic              ad_oe_o,
    input  logic [DW-1:0]     ad_i,
    input  logic              trdy_i,
    input  logic              stop_i,
    input  logic              tgt_sel_i
);
    localparam int BEW = DW / 8;

    bbi_state_t        st, st_nx;
    logic [BEW-1:0]    cmd_q;
    logic              drop_q, more_q, abort_q;
    logic              is_write, xfer, last_c, one_left, words_after;
    logic [DW-1:0]     addr_cur;
    logic [LW-1:0]     rem;

    assign is_write    = cmd_q[0];
    assign xfer        = (st == ST_DATA) && trdy_i;
    assign last_c      = one_left || drop_q || !bus_gnt_i;
    assign words_after = !(xfer && one_left);

    bbi_word_tracker #(.DW(DW), .LW(LW), .STEP(BEW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      ((st == ST_IDLE) && start_i),
        .load_addr_i (addr_i),
        .load_len_i  (len_i),
        .advance_i   (xfer),
        .addr_o      (addr_cur),
        .rem_o       (rem),
        .one_left_o  (one_left)
    );

    bbi_read_capture #(.DW(DW)) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (xfer && !is_write),
        .data_i    (ad_i),
        .addr_i    (addr_cur),
        .valid_o   (rd_valid_o),
        .data_o    (rd_data_o),
        .addr_o    (rd_addr_o)
    );

    // state register and tenure bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cmd_q   <= '0;
            drop_q  <= 1'b0;
            more_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            st <= st_nx;
            if ((st == ST_IDLE) && start_i) begin
                cmd_q   <= cmd_i;
                abort_q <= 1'b0;
                more_q  <= 1'b0;
            end
            if (st == ST_DATA) begin
                drop_q <= drop_q || last_c;
                if (stop_i || (xfer && last_c)) begin
                    more_q  <= words_after && !(stop_i && !tgt_sel_i);
                    abort_q <= stop_i && !tgt_sel_i;
                end
            end else begin
                drop_q <= 1'b0;
            end
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (start_i) st_nx = ST_ARB;
            ST_ARB:     if (bus_gnt_i && bus_idle_i) st_nx = ST_ADDR;
            ST_ADDR:    st_nx = is_write ? ST_DATA : ST_TURN;
            ST_TURN:    st_nx = ST_DATA;
            ST_DATA:    if (stop_i || (xfer && last_c)) st_nx = ST_RECOVER;
            ST_RECOVER: st_nx = more_q ? ST_ARB : ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frame_o   = 1'b0;
        irdy_o    = 1'b0;
        ctl_oe_o  = 1'b0;
        cbe_o     = '0;
        ad_o      = '0;
        ad_oe_o   = 1'b0;
        bus_req_o = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_ARB: bus_req_o = 1'b1;
            ST_ADDR: begin
                bus_req_o = 1'b1;
                frame_o   = 1'b1;
                ctl_oe_o  = 1'b1;
                cbe_o     = cmd_q;
                ad_o      = addr_cur;
                ad_oe_o   = 1'b1;
            end
            ST_TURN: begin
                bus_req_o = 1'b1;
                frame_o   = 1'b1;
                ctl_oe_o  = 1'b1;
                cbe_o     = '1;
            end
            ST_DATA: begin
                bus_req_o = 1'b1;
                frame_o   = !last_c;
                irdy_o    = 1'b1;
                ctl_oe_o  = 1'b1;
                cbe_o     = '1;
                ad_oe_o   = is_write;
                ad_o      = is_write ? wr_data_i : '0;
            end
            ST_RECOVER: ;
            default: ;
        endcase
    end

    assign busy_o     = (st != ST_IDLE);
    assign done_o     = (st == ST_RECOVER) && !more_q;
    assign abort_o    = abort_q;
    assign cur_addr_o = addr_cur;

    // R2: a rising frame opens the address phase with the command driven
    a_r2_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |-> (ad_oe_o && ctl_oe_o && (cbe_o == cmd_q)));

    // R4: a lowered frame stays low through wait states
    a_r4_frame_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_o && !frame_o && !trdy_i && !stop_i) |=> (irdy_o && !frame_o));

    // R5: ready holds while frame says more words follow
    a_r5_irdy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_o && frame_o && !stop_i) |=> irdy_o);

    // R6: the data phase always has words left
    a_r6_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |-> (rem != '0));

    // R7: a read address phase is followed by a released turnaround cycle
    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && !is_write) |=> (!ad_oe_o && !irdy_o));

    // R7: captured read data follows a real transfer
    a_r7_capture_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(irdy_o && trdy_i));

    // R11: the end of a data phase releases every driver for a cycle
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irdy_o) && !irdy_o) |-> (!ctl_oe_o && !ad_oe_o));
endmodule

// File: tb/burst_initiator_bench.sv
module burst_initiator_bench;
    localparam int DW = 32;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    cmd = '0;
    logic [31:0]   addr = '0;
    logic [LW-1:0] len = '0;
    logic [31:0]   wr_data;
    logic          busy, done, abrt, rd_valid, bus_req, frame, irdy, ctl_oe, ad_oe;
    logic [31:0]   cur_addr, rd_data, rd_addr, ad_out;
    logic [3:0]    cbe;
    logic          gnt = 1'b0, bus_idle = 1'b1, trdy = 1'b0, stop = 1'b0, tsel = 1'b1;
    logic [31:0]   ad_in = '0;

    int checks = 0, errors = 0;
    int cycles = 0;
    bit running = 0;
    // scenario knobs
    int k_len = 1, k_wait = 0, k_stop_at = 99, k_stop_kind = 1, k_stop_data = 0, k_gdrop_at = 99;
    logic [31:0] k_base = '0;
    bit k_write = 0;
    // observation state
    int words_done = 0, tenures = 0, rd_seen = 0, wcnt = 0;
    bit stop_used = 0, gd_done = 0, gd_active = 0, prev_addr = 0;

    function automatic logic [31:0] rd_fn(input logic [31:0] a);
        return a * 32'd3 + 32'h1357;
    endfunction
    function automatic logic [31:0] wr_fn(input logic [31:0] a);
        return ~a ^ 32'h00FF00FF;
    endfunction

    assign wr_data = wr_fn(cur_addr);

    burst_initiator #(.DW(DW), .LW(LW)) u_burst_initiator (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .addr_i(addr),
        .len_i(len), .wr_data_i(wr_data), .busy_o(busy), .done_o(done),
        .abort_o(abrt), .cur_addr_o(cur_addr), .rd_valid_o(rd_valid),
        .rd_data_o(rd_data), .rd_addr_o(rd_addr), .bus_req_o(bus_req),
        .bus_gnt_i(gnt), .bus_idle_i(bus_idle), .frame_o(frame), .irdy_o(irdy),
        .ctl_oe_o(ctl_oe), .cbe_o(cbe), .ad_o(ad_out), .ad_oe_o(ad_oe),
        .ad_i(ad_in), .trdy_i(trdy), .stop_i(stop), .tgt_sel_i(tsel)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // target and arbiter model plus monitor
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (!ctl_oe) gd_active = 0;
            if (irdy && !gd_done && words_done == k_gdrop_at) begin
                gd_done = 1;
                gd_active = 1;
            end
            gnt = gd_active ? 1'b0 : bus_req;
            if (irdy) begin
                if (!stop_used && words_done == k_stop_at) begin
                    stop_used = 1;
                    stop = 1'b1;
                    trdy = k_stop_data[0];
                    tsel = k_stop_kind[0];
                end else begin
                    stop = 1'b0;
                    tsel = 1'b1;
                    trdy = (wcnt >= k_wait);
                    wcnt++;
                end
            end else begin
                stop = 1'b0;
                trdy = 1'b0;
                tsel = 1'b1;
                wcnt = 0;
            end
            ad_in = rd_fn(cur_addr);
            #1;
            if (prev_addr) begin
                if (!k_write) chk(!ad_oe && !irdy && ctl_oe, "R7", "turnaround after address", {ad_oe, irdy}, 0);
                else          chk(irdy, "R5", "write data right after address", irdy, 1);
            end
            prev_addr = 0;
            if (ctl_oe && !irdy && ad_oe) begin
                tenures++;
                prev_addr = 1;
                chk(frame && ad_out == k_base + words_done * 4, "R2", "address phase address", ad_out, k_base + words_done * 4);
                chk(cbe == {3'b011, k_write}, "R2", "address phase command", cbe, {3'b011, k_write});
            end
            if (irdy)
                chk(frame == !((k_len - words_done) == 1 || gd_active || (gd_done && words_done == k_gdrop_at)),
                    "R4", "frame during data", frame, 0);
            if (irdy && trdy) begin
                chk(cur_addr == k_base + words_done * 4, "R3", "transfer address", cur_addr, k_base + words_done * 4);
                if (k_write) chk(ad_oe && ad_out == wr_fn(cur_addr), "R3", "write data", ad_out, wr_fn(cur_addr));
                words_done++;
                wcnt = 0;
            end
            if (rd_valid) begin
                chk(rd_addr == k_base + rd_seen * 4 && rd_data == rd_fn(rd_addr), "R7", "read capture",
                    rd_data, rd_fn(k_base + rd_seen * 4));
                rd_seen++;
            end
            if (done) chk(!ctl_oe && !ad_oe, "R11", "drivers released at done", {ctl_oe, ad_oe}, 0);
        end
    end

    task automatic run(input bit wr, input logic [31:0] base, input int ln, input int wt,
                       input int sa, input int skind, input int sdata, input int ga, input int hold);
        int eff, exp_words, exp_ten;
        bit exp_abort, seen_done;
        eff = (ln == 0) ? 1 : ln;
        exp_abort = (sa < eff) && (skind == 0);
        exp_words = exp_abort ? sa + sdata : eff;
        exp_ten = 1 + ((sa < eff && skind == 1 && sa + sdata < eff) ? 1 : 0)
                    + ((ga < eff && ga + 1 < eff) ? 1 : 0);
        @(negedge clk);
        k_write = wr; k_base = base; k_len = eff; k_wait = wt;
        k_stop_at = sa; k_stop_kind = skind; k_stop_data = sdata; k_gdrop_at = ga;
        words_done = 0; tenures = 0; rd_seen = 0; wcnt = 0;
        stop_used = 0; gd_done = 0; gd_active = 0; prev_addr = 0;
        cmd = {3'b011, wr}; addr = base; len = LW'(ln);
        bus_idle = (hold == 0);
        start = 1'b1;
        running = 1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < hold; i++) begin
            #2;
            chk(bus_req && !frame && !ctl_oe, "R2", "no address phase while bus busy", frame, 0);
            @(negedge clk);
        end
        bus_idle = 1'b1;
        seen_done = 0;
        for (int i = 0; i < 400 && !seen_done; i++) begin
            #2;
            if (done) seen_done = 1;
            else @(negedge clk);
        end
        chk(seen_done, "R11", "done pulse", seen_done, 1);
        chk(abrt == exp_abort, exp_abort ? "R9" : "R8", "abort flag", abrt, exp_abort);
        chk(words_done == exp_words, (sa < eff) ? "R8" : "R6", "words moved", words_done, exp_words);
        chk(tenures == exp_ten, (ga < eff) ? "R10" : "R8", "tenure count", tenures, exp_ten);
        if (!wr) chk(rd_seen == exp_words, "R7", "read words captured", rd_seen, exp_words);
        @(negedge clk);
        #2;
        chk(!busy && !done, "R11", "idle after done", busy, 0);
        running = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !frame && !irdy && !ctl_oe && !ad_oe && !done && !rd_valid,
            "R1", "reset outputs", {busy, bus_req, frame, irdy, ctl_oe, ad_oe, done, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!busy && !bus_req, "R1", "idle after reset release", busy, 0);
        // sweep: direction x length (0 means one word) x wait states
        for (int d = 0; d < 2; d++)
            for (int l = 0; l <= 5; l++)
                for (int w = 0; w <= 2; w++)
                    run(d[0], 32'h100 + 32'(l) * 32'h40, l, w, 99, 1, 0, 99, 0);
        // R8 retry at every word position, with and without data on the stop edge
        for (int d = 0; d < 2; d++)
            for (int l = 1; l <= 4; l++)
                for (int s = 0; s < l; s++)
                    for (int sd = 0; sd < 2; sd++)
                        run(d[0], 32'h2000, l, 1, s, 1, sd, 99, 0);
        // R9 abort
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 3; s++)
                for (int sd = 0; sd < 2; sd++)
                    run(d[0], 32'h3000, 4, 0, s, 0, sd, 99, 0);
        // R10 grant withdrawn at each position
        for (int d = 0; d < 2; d++)
            for (int g = 0; g < 4; g++)
                run(d[0], 32'h4000, 4, d, 99, 1, 0, g, 0);
        // R2 arbitration waits for an idle bus
        run(1'b1, 32'h5000, 3, 0, 99, 1, 0, 99, 3);
        run(1'b0, 32'h5100, 2, 1, 99, 1, 0, 99, 2);
        finish_run();
    end
endmodule